// File: doc/BRIEF.md
# Buffered Repeat-Count Pulse Timer

This block is a down-counting timer for a slow clock. It produces trains of underflow events. Software programs a top value, which is the period in ticks minus one, and a repeat count, which is the number of periods to run. Each time the counter passes zero it reloads from the top value, and the repeat count drops by one. When the repeat count runs out the run ends. In buffered mode a second top value and a second repeat count wait in a buffer. If the buffer repeat count has been written since the last hand-over, the buffered pair replaces the active pair at the final underflow. The next period then follows with no gap. A sequence handler can refill the buffer from the repeat-done interrupt and chain sequences of different periods indefinitely. If it does not refill, the timer stops by itself.

The counter only moves on cycles where `tick` is high. `tick` is a clock-enable that stands for the slow clock, and it must already be synchronous to `clk`. Two event outputs each follow the underflows, either as a one-cycle pulse or as a level that toggles. Two sticky flags record underflow and repeat-done. Each flag has its own enable into a single interrupt request. All programming goes through a write-only register port. The count, the repeat count, the run state and the buffer state come out as plain outputs.

Register map (word addresses on `wr_addr`):
- 0: mode. Bit 0 selects buffered mode. Bits [2i+2:2i+1] hold the action code of event output i (00 off, 01 toggle, 10 pulse, 11 off).
- 1: command. Bit 0 starts the timer and bit 1 stops it. If both bits are set, stop wins.
- 2: active top value.
- 3: active repeat count.
- 4: buffer top value.
- 5: buffer repeat count. Writing it marks the buffer full.
- 6: interrupt enables. Bit 0 enables underflow and bit 1 enables repeat-done.
- 7: flag clear. Writing 1 to a bit clears the matching flag.

Top module: `pulse_seq_timer`

## Requirements
- R1: After reset the count, repeat count, run state, buffer-full state, both flags, both event outputs and the interrupt request are all 0.
- R2: A start command loads the count from the active top value and sets the run state. While running, each tick decrements a non-zero count. A count of 0 is an underflow, which reloads the top value on that same tick, so a top value of N gives one underflow every N+1 ticks. Without a tick the count holds.
- R3: Every underflow sets flag bit 0 and lowers a non-zero repeat count by one.
- R4: An underflow that meets a repeat count of 1 or 0 is the expiry of the sequence, and it sets flag bit 1.
- R5: In buffered mode, if the buffer is full at expiry, the count and the active top value take the buffer top value, and the active repeat count takes the buffer repeat count. All three take effect on the expiry tick. The buffer-full state clears and the timer keeps running.
- R6: At expiry in unbuffered mode, or with an empty buffer, the run state clears and the count stays at 0.
- R7: For action code 01 an event output inverts one cycle after each underflow tick. For code 10 it is high for exactly the cycle after each underflow tick. For codes 00 and 11 it is low.
- R8: The interrupt request is high exactly when some flag is set with its enable bit set. Flags stay set until cleared through the flag-clear register. If a set and a clear land in the same cycle, the set wins.
- R9: A stop command clears the run state and freezes the count. Ticks while stopped change neither the count nor the flags.
- R10: A write to the buffer repeat count in the same cycle as a hand-over leaves the buffer full and holds the new value. The hand-over itself uses the buffer contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-clock enable, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | CNT_W | Register write data |
| evt_out | output | NOUT | Event outputs, pulse or toggle per channel |
| irq | output | 1 | Interrupt request |
| flags_o | output | 2 | Sticky flags: bit 0 underflow, bit 1 repeat-done |
| cnt_o | output | CNT_W | Current count |
| rep_o | output | REP_W | Active repeat count |
| running_o | output | 1 | Run state |
| buf_full_o | output | 1 | Buffer repeat count written and not yet consumed |

## Verification
The bench aims at the expiry tick. A design that reloads the old top value there, instead of taking the buffer, would stretch the second sequence. A design that hands over without the full mark would never stop, and one that stops while the buffer is full would cut the train short. Random runs with random tick gaps compare the total ticks to the stop, and the number of pulses, against the sum of the two sequence lengths. An off-by-one in the period or the repeat count therefore shows up as a wrong total. Directed cases cover the following:
- a buffer write in the hand-over cycle, which a wrong design would lose;
- ticks after a stop, which a wrong design would still count;
- the single-cycle pulse against the toggle;
- flag masking and clearing.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_PULSE  = 2'b10,
    ACT_OFF2   = 2'b11
  } out_act_e;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NFLAG  = 2;
  localparam int unsigned FLAG_UF   = 0;
  localparam int unsigned FLAG_DONE = 1;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_REP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_BTOP = 3'd4;
  localparam logic [ADDR_W-1:0] A_BREP = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;
  localparam logic [ADDR_W-1:0] A_ICLR = 3'd7;
endpackage

// File: rtl/pst_regs.sv
module pst_regs
  import pst_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8,
  parameter int unsigned NOUT  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic                   consume,
  output logic                   buffered,
  output logic [NOUT-1:0][1:0]   act,
  output logic [NFLAG-1:0]       ien,
  output logic [NFLAG-1:0]       clr,
  output logic                   start_cmd,
  output logic                   stop_cmd,
  output logic                   wr_top,
  output logic                   wr_rep,
  output logic [CNT_W-1:0]       btop,
  output logic [REP_W-1:0]       brep,
  output logic                   bvalid
);
  localparam int unsigned MODE_W = 2 * NOUT + 1;

  logic [MODE_W-1:0] mode_q;
  logic              wr_brep;

  assign wr_brep   = wr_en && (wr_addr == A_BREP);
  assign wr_top    = wr_en && (wr_addr == A_TOP);
  assign wr_rep    = wr_en && (wr_addr == A_REP);
  assign stop_cmd  = wr_en && (wr_addr == A_CMD) && wr_data[1];
  assign start_cmd = wr_en && (wr_addr == A_CMD) && wr_data[0] && !wr_data[1];
  assign clr       = (wr_en && (wr_addr == A_ICLR)) ? wr_data[NFLAG-1:0] : '0;
  assign buffered  = mode_q[0];

  for (genvar i = 0; i < NOUT; i++) begin : g_act
    assign act[i] = mode_q[2*i+2 -: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien    <= '0;
      btop   <= '0;
      brep   <= '0;
      bvalid <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data[MODE_W-1:0];
      if (wr_en && wr_addr == A_IEN)  ien    <= wr_data[NFLAG-1:0];
      if (wr_en && wr_addr == A_BTOP) btop   <= wr_data;
      if (wr_brep)                    brep   <= wr_data[REP_W-1:0];
      if (wr_brep)      bvalid <= 1'b1;
      else if (consume) bvalid <= 1'b0;
    end
  end

  // R10: a buffer repeat write always leaves the buffer full
  p_buf_refill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_brep |=> bvalid);
  // R5: a hand-over without a refill empties the buffer
  p_buf_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !wr_brep) |=> !bvalid);
endmodule

// File: rtl/pst_core.sv
module pst_core
  import pst_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             wr_top,
  input  logic             wr_rep,
  input  logic [CNT_W-1:0] wdata,
  input  logic             buffered,
  input  logic [CNT_W-1:0] btop,
  input  logic [REP_W-1:0] brep,
  input  logic             bvalid,
  output logic [CNT_W-1:0] cnt,
  output logic [REP_W-1:0] rep,
  output logic             running,
  output logic             uf_evt,
  output logic             done_evt,
  output logic             handover
);
  logic [CNT_W-1:0] top_q;
  logic             adv;

  function automatic logic [REP_W-1:0] rep_after(input logic [REP_W-1:0] r);
    return (r == '0) ? r : r - 1'b1;
  endfunction

  function automatic logic rep_last(input logic [REP_W-1:0] r);
    return r <= REP_W'(1);
  endfunction

  assign adv      = tick && running && !start_cmd && !stop_cmd;
  assign uf_evt   = adv && (cnt == '0);
  assign done_evt = uf_evt && rep_last(rep);
  assign handover = done_evt && buffered && bvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (stop_cmd) begin
      running <= 1'b0;
    end else if (start_cmd) begin
      running <= 1'b1;
      cnt     <= top_q;
    end else if (adv) begin
      if (cnt != '0)    cnt <= cnt - 1'b1;
      else if (!done_evt) cnt <= top_q;
      else if (handover)  cnt <= btop;
      else                running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      rep   <= '0;
    end else begin
      if (wr_top)        top_q <= wdata;
      else if (handover) top_q <= btop;
      if (wr_rep)        rep <= wdata[REP_W-1:0];
      else if (handover) rep <= brep;
      else if (uf_evt)   rep <= rep_after(rep);
    end
  end

  // R2: a running non-zero count steps down by one per tick
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R9: while stopped and not started, the count is frozen
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_cmd) |=> $stable(cnt) && !running);
  // R5: a hand-over continues the run from the buffered top value
  p_handover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    handover |=> running && cnt == $past(btop));
  // R6: expiry without a hand-over ends the run at zero
  p_selfstop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !handover) |=> !running && cnt == '0);
endmodule

// File: rtl/pst_out.sv
module pst_out
  import pst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] act,
  input  logic       uf,
  output logic       out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b0;
    else begin
      case (act)
        ACT_TOGGLE: out <= out ^ uf;
        ACT_PULSE:  out <= uf;
        default:    out <= 1'b0;
      endcase
    end
  end

  // R7: in pulse mode the output is high only right after an underflow
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_PULSE && $past(act) == ACT_PULSE && out) |-> $past(uf));
  // R7: in toggle mode the level moves only after an underflow
  p_toggle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_TOGGLE && $past(act) == ACT_TOGGLE && !$past(uf)) |-> $stable(out));
endmodule

// File: rtl/pst_irq.sv
module pst_irq
  import pst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  input  logic [NFLAG-1:0] ien,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  assign irq = |(flags & ien);

  // R3: an underflow always leaves its flag set
  p_uf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set[FLAG_UF] |=> flags[FLAG_UF]);
  // R8: flags are sticky unless cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLAG_DONE] && !clr[FLAG_DONE]) |=> flags[FLAG_DONE]);
  // R8: a clear without a set empties the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[FLAG_UF] && !set[FLAG_UF]) |=> !flags[FLAG_UF]);
endmodule

// File: rtl/pulse_seq_timer.sv
module pulse_seq_timer
  import pst_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8,
  parameter int unsigned NOUT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NOUT-1:0]   evt_out,
  output logic              irq,
  output logic [NFLAG-1:0]  flags_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [REP_W-1:0]  rep_o,
  output logic              running_o,
  output logic              buf_full_o
);
  logic                 buffered, start_cmd, stop_cmd, wr_top, wr_rep;
  logic [NOUT-1:0][1:0] act;
  logic [NFLAG-1:0]     ien, clr, set;
  logic [CNT_W-1:0]     btop;
  logic [REP_W-1:0]     brep;
  logic                 bvalid, uf_evt, done_evt, handover;

  pst_regs #(.CNT_W(CNT_W), .REP_W(REP_W), .NOUT(NOUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .consume(handover), .buffered(buffered), .act(act),
    .ien(ien), .clr(clr), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .wr_top(wr_top), .wr_rep(wr_rep), .btop(btop), .brep(brep),
    .bvalid(bvalid)
  );

  pst_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .wr_top(wr_top), .wr_rep(wr_rep), .wdata(wr_data),
    .buffered(buffered), .btop(btop), .brep(brep), .bvalid(bvalid),
    .cnt(cnt_o), .rep(rep_o), .running(running_o), .uf_evt(uf_evt),
    .done_evt(done_evt), .handover(handover)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    pst_out u_out (
      .clk(clk), .rst_n(rst_n), .act(act[i]), .uf(uf_evt), .out(evt_out[i])
    );
  end

  assign set[FLAG_UF]   = uf_evt;
  assign set[FLAG_DONE] = done_evt;

  pst_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(set), .clr(clr), .ien(ien),
    .flags(flags_o), .irq(irq)
  );

  assign buf_full_o = bvalid;

  // R4: expiry flag follows every expiring underflow
  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flags_o[FLAG_DONE]);
endmodule

// File: tb/pulse_seq_timer_test.sv
module pulse_seq_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  evt_out;
  logic        irq;
  logic [1:0]  flags_o;
  logic [15:0] cnt_o;
  logic [7:0]  rep_o;
  logic        running_o, buf_full_o;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pulse_seq_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt_out(evt_out), .irq(irq), .flags_o(flags_o),
    .cnt_o(cnt_o), .rep_o(rep_o), .running_o(running_o), .buf_full_o(buf_full_o)
  );

  // mode word: bit0 buffered, [2:1] out0 action, [4:3] out1 action
  function automatic int mode_word(input bit buf_on, input int a0, input int a1);
    return (buf_on ? 1 : 0) + a0 * 2 + a1 * 8;
  endfunction

  // ticks from start to self-stop for one sequence
  function automatic int seq_len(input int top, input int reps);
    return (top + 1) * ((reps < 1) ? 1 : reps);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(posedge clk); #1;
  endtask

  task automatic wr_tick(input int a, input int d);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(posedge clk); #1;
  endtask

  task automatic step(input bit t);
    @(negedge clk);
    tick = t; wr_en = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t0, r0, t1, r1, n_tick, n_pulse, tog0, guard;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(cnt_o == 0 && rep_o == 0 && !running_o && !buf_full_o, "R1 state", cnt_o, 0);
    chk(flags_o == 0 && evt_out == 0 && !irq, "R1 outputs", {flags_o, evt_out}, 0);
    @(negedge clk); rst_n = 1'b1;

    // unbuffered, out0 pulse, out1 toggle
    wr(0, mode_word(0, 2, 1)); wr(2, 2); wr(3, 3); wr(1, 1);
    chk(cnt_o == 2 && running_o, "R2 start load", cnt_o, 2);
    step(1); step(1);
    chk(cnt_o == 0 && flags_o == 0, "R2 countdown", cnt_o, 0);
    step(1);
    chk(cnt_o == 2 && rep_o == 2, "R2 reload/R3 rep dec", rep_o, 2);
    chk(flags_o == 2'b01, "R3 uf flag", flags_o, 1);
    chk(evt_out == 2'b11, "R7 pulse+toggle", evt_out, 3);
    step(0);
    chk(evt_out == 2'b10, "R7 pulse one cycle", evt_out, 2);
    chk(cnt_o == 2, "R2 hold without tick", cnt_o, 2);
    chk(!irq, "R8 masked", irq, 0);
    wr(6, 1);
    chk(irq, "R8 enabled uf", irq, 1);
    wr(6, 2);
    chk(!irq, "R8 done not set", irq, 0);
    wr(7, 1);
    chk(flags_o == 0, "R8 clear", flags_o, 0);
    repeat (5) step(1);
    chk(running_o && rep_o == 1, "R4 not yet", rep_o, 1);
    step(1);
    chk(!running_o && cnt_o == 0, "R6 self-stop", running_o, 0);
    chk(flags_o == 2'b11 && irq, "R4 done flag", flags_o, 3);
    chk(evt_out[1] == 1'b1, "R7 toggle parity", evt_out[1], 1);

    // stop command
    wr(7, 3); wr(3, 3); wr(1, 1); step(1);
    chk(cnt_o == 1, "R9 pre-stop", cnt_o, 1);
    wr(1, 2);
    repeat (4) step(1);
    chk(cnt_o == 1 && !running_o && flags_o == 0, "R9 frozen", cnt_o, 1);

    // buffered hand-over: 3x3 then 4x2
    wr(0, mode_word(1, 2, 1)); wr(2, 2); wr(3, 3); wr(4, 1); wr(5, 4);
    chk(buf_full_o, "R5 buffer full", buf_full_o, 1);
    wr(1, 1);
    repeat (9) step(1);
    chk(running_o && cnt_o == 1 && rep_o == 4, "R5 hand-over", {cnt_o[7:0], rep_o}, 'h0104);
    chk(!buf_full_o && flags_o[1], "R5 buffer consumed", buf_full_o, 0);
    repeat (7) step(1);
    chk(running_o, "R6 still running", running_o, 1);
    step(1);
    chk(!running_o && cnt_o == 0, "R6 stop after buffer", running_o, 0);

    // refill in hand-over cycle
    wr(7, 3); wr(2, 0); wr(3, 1); wr(4, 0); wr(5, 1); wr(1, 1);
    wr_tick(5, 3);
    chk(running_o && rep_o == 1 && buf_full_o, "R10 refill kept", {rep_o, 7'd0, buf_full_o}, 'h0101);
    step(1);
    chk(running_o && rep_o == 3 && !buf_full_o, "R10 new value", rep_o, 3);
    step(1); step(1);
    chk(running_o, "R10 running", running_o, 1);
    step(1);
    chk(!running_o, "R10 stop", running_o, 0);

    // random chained sequences with tick gaps
    for (int it = 0; it < 20; it++) begin
      t0 = int'($urandom_range(0, 4)); r0 = int'($urandom_range(1, 3));
      t1 = int'($urandom_range(0, 4)); r1 = int'($urandom_range(1, 3));
      wr(2, t0); wr(3, r0); wr(4, t1); wr(5, r1);
      tog0 = int'(evt_out[1]);
      wr(1, 1);
      n_tick = 0; n_pulse = 0; guard = 0;
      while (running_o && guard < 2000) begin
        bit tk;
        tk = ($urandom_range(0, 2) != 0);
        step(tk);
        if (tk) n_tick++;
        if (evt_out[0]) n_pulse++;
        guard++;
      end
      chk(n_tick == seq_len(t0, r0) + seq_len(t1, r1), "R5 chained length", n_tick,
          seq_len(t0, r0) + seq_len(t1, r1));
      chk(n_pulse == r0 + r1, "R3 pulse count", n_pulse, r0 + r1);
      chk(int'(evt_out[1]) == (tog0 ^ ((r0 + r1) % 2)), "R7 toggle parity", evt_out[1],
          tog0 ^ ((r0 + r1) % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule